// File: doc/BRIEF.md
# Windowed Spike-Rate Estimator Bank

This block measures how often each neuron in a group of seven fires during one run. A start strobe opens a counting window and clears one spike counter per neuron. While the window is open, each counter advances by one in every cycle in which its neuron's spike input is high. An end strobe closes the window, and the block then turns each raw count into a rate by a single fixed-point multiply with a host-programmed Q16.16 factor.

The seven multiplies share one multiplier and run one neuron per cycle, starting with neuron 0. Each product keeps its integer part and is clamped to 32 bits. It is then written to that neuron's rate register. A results-valid flag rises only after the last of the seven registers has been written. Rate registers keep their earlier contents until the new products overwrite them, so the host can keep reading the previous run while the next one counts.

Top module: `spike_rate_bank`

## Requirements
- R1: After reset every rate register reads 0 and `rates_valid` is 0.
- R2: A neuron's count equals the number of cycles in which its `spike` bit is high, counting from the cycle in which `win_start` is high through the cycle in which `win_end` is high, both included.
- R3: Spikes in cycles outside an open window do not change any count. A new window's count starts from zero.
- R4: At the end of a window, rate[i] = floor(count[i] * scale / 65536), where `scale` is unsigned Q16.16 and the rate is Q16.16.
- R5: If that quotient exceeds 0xFFFFFFFF, rate[i] is 0xFFFFFFFF.
- R6: `rates_valid` falls in the cycle after `win_start` and stays 0 while products are being written. It rises at the 7th rising edge after the edge that sampled `win_end`, together with the write of neuron 6.
- R7: While a new window counts, the rate registers keep the values of the previous run.
- R8: A `win_end` pulse with no window open is ignored: `rates_valid` and all rates stay unchanged.
- R9: Neuron i's rate appears on `rate_flat[32*i+31:32*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| win_start | input | 1 | Opens the window and clears the counters; has priority over win_end |
| win_end | input | 1 | Last counted cycle of the window; starts the scaling pass |
| spike | input | 7 | One spike pulse bit per neuron |
| scale | input | 32 | Unsigned Q16.16 scale factor, sampled during the scaling pass |
| rate_flat | output | 224 | Seven Q16.16 rates, neuron 0 in the low 32 bits |
| rates_valid | output | 1 | High when all seven rates belong to the last finished window |

## Verification
A counter that mis-counts, misses the window edges or keeps counting after the window closes shows up only once the scaling pass has finished, as a wrong rate on that neuron's slice, seven cycles after the end strobe. A scaling pass that writes the wrong slot or runs too long shows up as a rate that changes while a later window counts, or as a valid flag that rises in the wrong cycle. Because the rates are compared against values the bench computes itself, an error shows up in the first run that exercises the faulty path.

// File: rtl/spike_rate_bank.sv
module spike_rate_bank #(
  parameter int N  = 7,
  parameter int CW = 20,
  parameter int RW = 32,
  parameter int FB = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_start,
  input  logic            win_end,
  input  logic [N-1:0]    spike,
  input  logic [RW-1:0]   scale,
  output logic [N*RW-1:0] rate_flat,
  output logic            rates_valid
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = CW + RW;
  localparam int SW = PW - FB;

  logic          active, scaling;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt [N];
  logic [RW-1:0] rate [N];
  logic [CW-1:0] cnt_sel;
  logic [PW-1:0] prod;
  logic [SW-1:0] shifted;
  logic [RW-1:0] clamped;
  logic          last;

  assign cnt_sel = cnt[idx];
  assign prod    = PW'(cnt_sel) * PW'(scale);
  assign shifted = prod[PW-1:FB];
  assign last    = (idx == IW'(N-1));

  generate
    if (SW > RW) begin : g_sat
      assign clamped = (|shifted[SW-1:RW]) ? {RW{1'b1}} : shifted[RW-1:0];
    end else begin : g_nosat
      assign clamped = RW'(shifted);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      scaling     <= 1'b0;
      idx         <= '0;
      rates_valid <= 1'b0;
    end else if (win_start) begin
      active      <= 1'b1;
      scaling     <= 1'b0;
      idx         <= '0;
      rates_valid <= 1'b0;
    end else if (active && win_end) begin
      active  <= 1'b0;
      scaling <= 1'b1;
      idx     <= '0;
    end else if (scaling) begin
      idx <= idx + 1'b1;
      if (last) begin
        scaling     <= 1'b0;
        rates_valid <= 1'b1;
      end
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_nrn
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt[i] <= '0;
        else if (win_start)
          cnt[i] <= CW'(spike[i]);
        else if (active && spike[i] && !(&cnt[i]))
          cnt[i] <= cnt[i] + 1'b1;
      end

      always_ff @(posedge clk) begin
        if (!rst_n)
          rate[i] <= '0;
        else if (scaling && !win_start && idx == IW'(i))
          rate[i] <= clamped;
      end

      assign rate_flat[i*RW +: RW] = rate[i];
    end
  endgenerate
endmodule

// File: rtl/spike_rate_bank_chk.sv
module spike_rate_bank_chk #(
  parameter int N  = 7,
  parameter int RW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            win_start,
  input logic            win_end,
  input logic            active,
  input logic            scaling,
  input logic [N*RW-1:0] rate_flat,
  input logic            rates_valid
);
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> !rates_valid); // R6

  AST_VALID_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rates_valid) |-> $past(scaling)); // R6

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rates_valid |-> (!active && !scaling)); // R6

  AST_RATES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(scaling) |-> $stable(rate_flat)); // R7

  AST_STRAY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_start && !active && !scaling) |=> ($stable(rates_valid) && $stable(rate_flat))); // R8
endmodule

bind spike_rate_bank spike_rate_bank_chk #(.N(N), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
  .active(active), .scaling(scaling), .rate_flat(rate_flat),
  .rates_valid(rates_valid));

// File: tb/tb_spike_rate_bank.sv
module tb_spike_rate_bank;
  localparam int N = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          win_start = 0, win_end = 0;
  logic [N-1:0]  spike = '0;
  logic [31:0]   scale = '0;
  logic [N*32-1:0] rate_flat;
  logic          rates_valid;

  int checks = 0, failures = 0;
  bit done = 0;
  longint exp_cnt [N];
  logic [31:0] exp_rate [N];

  spike_rate_bank dut (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
    .spike(spike), .scale(scale), .rate_flat(rate_flat), .rates_valid(rates_valid));

  always #5 clk = ~clk;

  // {scale, length, seed}
  localparam logic [63:0] VEC [6] = '{
    {32'h0001_0000, 16'd40,  16'd0},
    {32'h0000_8000, 16'd57,  16'd3},
    {32'h0002_4000, 16'd123, 16'd1},
    {32'h0000_0001, 16'd200, 16'd7},
    {32'h0000_0000, 16'd30,  16'd2},
    {32'hFFFF_FFFF, 16'd301, 16'd5}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit spk(int mode, int i, int c, int seed);
    if (mode == 1) return (i == 0);
    return ((c * (i + 2) + seed + i) % (i + 3)) == 0;
  endfunction

  function automatic logic [31:0] scaled(longint cnt, logic [31:0] s);
    longint unsigned q = (longint'(cnt) * longint'(s)) >> 16;
    return (q > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : q[31:0];
  endfunction

  task automatic check_rates(input string req);
    for (int i = 0; i < N; i++)
      chk(rate_flat[32*i +: 32] === exp_rate[i], req, rate_flat[32*i +: 32], exp_rate[i]);
  endtask

  task automatic run_window(input logic [31:0] s, input int len, input int seed, input int mode);
    for (int i = 0; i < N; i++) exp_cnt[i] = 0;
    scale = s;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c == len / 2 && c > 0) check_rates("R7 held during window");
      win_start = (c == 0);
      win_end   = (c == len - 1);
      for (int i = 0; i < N; i++) begin
        spike[i] = spk(mode, i, c, seed);
        if (spike[i]) exp_cnt[i]++;
      end
    end
    @(negedge clk);
    win_start = 0; win_end = 0; spike = '1;  // outside window: must be ignored (R3)
    chk(rates_valid === 1'b0, "R6 low after end", 32'(rates_valid), 0);
    repeat (6) @(negedge clk);
    chk(rates_valid === 1'b0, "R6 low before last write", 32'(rates_valid), 0);
    @(negedge clk);
    chk(rates_valid === 1'b1, "R6 high after 7 writes", 32'(rates_valid), 1);
    spike = '0;
    for (int i = 0; i < N; i++) exp_rate[i] = scaled(exp_cnt[i], s);
    check_rates("R2/R4/R9 rate");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) exp_rate[i] = 0;
    chk(rates_valid === 1'b0, "R1 valid after reset", 32'(rates_valid), 0);
    check_rates("R1 rates after reset");
    rst_n = 1;

    for (int v = 0; v < 6; v++)
      run_window(VEC[v][63:32], int'(VEC[v][31:16]), int'(VEC[v][15:0]), 0);

    // R3: spikes between windows, then a stray end (R8)
    spike = '1;
    repeat (10) @(negedge clk);
    win_end = 1;
    @(negedge clk);
    win_end = 0; spike = '0;
    repeat (10) @(negedge clk);
    chk(rates_valid === 1'b1, "R8 valid after stray end", 32'(rates_valid), 1);
    check_rates("R8 rates after stray end");

    // R3: fresh window counts from zero despite earlier stray spikes
    run_window(32'h0001_0000, 25, 4, 0);

    // R5: saturation with a long all-spike window on neuron 0
    run_window(32'hFFFF_FFFF, 70000, 0, 1);
    chk(exp_rate[0] === 32'hFFFF_FFFF, "R5 bench model saturates", exp_rate[0], 32'hFFFF_FFFF);
    chk(rate_flat[31:0] === 32'hFFFF_FFFF, "R5 saturated rate", rate_flat[31:0], 32'hFFFF_FFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule